// File: doc/BRIEF.md
# I2S Target-Mode Stereo Serial Transmitter

This block turns a parallel stereo packet, one left and one right sample of `SAMPLE_W` bits each, into an I2S serial stream. It is a bus target. It never makes its own bit clock or word select. Both come from the upstream controller, and the block passes them straight to its output bus. Because the receive path and the transmit path share the same clocks, the two paths cannot drift apart.

The block takes the next packet from its parallel input at a fixed point just before the current frame ends. It then shifts each word out MSB-first on the falling edges of the bit clock. If no fresh packet is offered at that point, the packet already held is sent again.

Top module: `i2s_tgt_tx`

## Requirements
- R1: `sclk_out` always equals `sclk_in` and `ws_out` always equals `ws_in`. Neither is delayed by a register.
- R2: While word select is low, the serial line carries the held left sample. While it is high, the line carries the held right sample. Each word is `SAMPLE_W` bits (default 16) and is sent MSB first.
- R3: A word starts one bit period after a word-select change. Its MSB is driven on the falling edge that follows the first rising edge at which the new word-select level is seen.
- R4: `sd_out` changes only on falling edges of `sclk_in`, so it is stable at every rising edge.
- R5: The stored packet is loaded on the falling edge that drives bit index `SAMPLE_W-2` of the right word, counting the MSB as index 0. That is one bit before the right LSB. Input changes made before this edge are used in the next frame. Changes made after it wait one more frame.
- R6: If `pkt_valid` is low at the load edge, the stored packet is kept and the previous packet is sent again.
- R7: While `rst_n` is low (asynchronous, active low), `sd_out` is 0 and both the shift register and the stored packet are cleared. Frames sent after reset carry zero samples until a valid packet is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Bit clock from the bus controller |
| ws_in | input | 1 | Word select from the controller (low = left, high = right) |
| left_in | input | SAMPLE_W | Left sample of the offered packet |
| right_in | input | SAMPLE_W | Right sample of the offered packet |
| pkt_valid | input | 1 | High when `left_in`/`right_in` hold a fresh packet |
| sclk_out | output | 1 | Forwarded bit clock |
| ws_out | output | 1 | Forwarded word select |
| sd_out | output | 1 | Serial data, changes on falling edges |

## Verification
The hardest behaviour to reach from the ports is the single load edge near the end of the right word. A packet change one bit before that edge must take effect in the next frame. A change one bit after it must be deferred by a whole frame.

The stimulus reaches this edge by driving the controller's word select itself. The bench switches the parallel input at chosen bit positions inside a frame, then decodes the two following frames with an independent I2S receiver model. Repeats are forced by offering packets with `pkt_valid` low. A reset in the middle of a right word, while the line is driving a 1, shows that the line and the stored packet clear.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;

   localparam int unsigned CH_COUNT = 2;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // word-select level to channel: low selects left, high selects right
   function automatic chan_e chan_of_ws(input logic ws_level);
      return ws_level ? CH_RIGHT : CH_LEFT;
   endfunction

endpackage

// File: rtl/i2s_tx_wsdet.sv
`timescale 1ns/1ps
module i2s_tx_wsdet (
   input  logic sclk_i,
   input  logic rst_ni,
   input  logic ws_i,
   output logic ws_level_o,
   output logic ws_flip_o
);

   logic ws_now_q;
   logic ws_old_q;

   // word select is sampled on the rising edge, where the controller keeps it stable
   always_ff @(posedge sclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ws_now_q <= 1'b0;
         ws_old_q <= 1'b0;
      end else begin
         ws_now_q <= ws_i;
         ws_old_q <= ws_now_q;
      end
   end

   assign ws_level_o = ws_now_q;
   assign ws_flip_o  = ws_now_q ^ ws_old_q;

endmodule

// File: rtl/i2s_tx_pkt_hold.sv
`timescale 1ns/1ps
module i2s_tx_pkt_hold
   import i2s_tx_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                              sclk_i,
   input  logic                              rst_ni,
   input  logic                              cap_i,
   input  logic                              valid_i,
   input  logic [CH_COUNT-1:0][SAMPLE_W-1:0] words_i,
   output logic [CH_COUNT-1:0][SAMPLE_W-1:0] words_o
);

   logic take;
   assign take = cap_i & valid_i;

   for (genvar g = 0; g < CH_COUNT; g++) begin : g_chan
      logic [SAMPLE_W-1:0] word_q;
      always_ff @(negedge sclk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            word_q <= '0;
         end else if (take) begin
            word_q <= words_i[g];
         end
      end
      assign words_o[g] = word_q;
   end

   // R5
   pkt_load_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      (cap_i && valid_i) |=> (words_o == $past(words_i)));

   // R6
   pkt_keep_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      !(cap_i && valid_i) |=> $stable(words_o));

endmodule

// File: rtl/i2s_tx_ser.sv
`timescale 1ns/1ps
module i2s_tx_ser
   import i2s_tx_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                              sclk_i,
   input  logic                              rst_ni,
   input  logic                              ws_level_i,
   input  logic                              ws_flip_i,
   input  logic [CH_COUNT-1:0][SAMPLE_W-1:0] words_i,
   output logic                              sd_o,
   output logic                              cap_o
);

   localparam int unsigned CNT_W = $clog2(SAMPLE_W) + 1;
   localparam logic [CNT_W-1:0] CAP_IDX = CNT_W'(SAMPLE_W - 3);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [SAMPLE_W-1:0] shift_q;
   logic [CNT_W-1:0]    bit_idx_q;
   chan_e               chan;

   assign chan = chan_of_ws(ws_level_i);

   // data moves on the falling edge; the counter stops at its top so a stalled bus loads nothing
   always_ff @(negedge sclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shift_q   <= '0;
         bit_idx_q <= '0;
      end else if (ws_flip_i) begin
         shift_q   <= words_i[chan];
         bit_idx_q <= '0;
      end else begin
         shift_q <= {shift_q[SAMPLE_W-2:0], 1'b0};
         if (bit_idx_q != CNT_TOP) begin
            bit_idx_q <= bit_idx_q + 1'b1;
         end
      end
   end

   assign sd_o  = shift_q[SAMPLE_W-1];
   assign cap_o = !ws_flip_i && (chan == CH_RIGHT) && (bit_idx_q == CAP_IDX);

   // R3
   left_msb_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      (ws_flip_i && !ws_level_i) |=> (sd_o == $past(words_i[0][SAMPLE_W-1])));

   // R3
   right_msb_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      (ws_flip_i && ws_level_i) |=> (sd_o == $past(words_i[1][SAMPLE_W-1])));

   // R5
   single_load_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
      cap_o |=> !cap_o);

endmodule

// File: rtl/i2s_tgt_tx.sv
`timescale 1ns/1ps
module i2s_tgt_tx
   import i2s_tx_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                rst_n,
   input  logic                sclk_in,
   input  logic                ws_in,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   input  logic                pkt_valid,
   output logic                sclk_out,
   output logic                ws_out,
   output logic                sd_out
);

   if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_width
      $error("i2s_tgt_tx: SAMPLE_W must lie between 4 and 32");
   end

   logic                              ws_level;
   logic                              ws_flip;
   logic                              cap;
   logic [CH_COUNT-1:0][SAMPLE_W-1:0] offered;
   logic [CH_COUNT-1:0][SAMPLE_W-1:0] held;

   // index 0 is the left channel, matching CH_LEFT
   assign offered = {right_in, left_in};

   // clocks are passed through untouched so both bus sides share one timing source
   assign sclk_out = sclk_in;
   assign ws_out   = ws_in;

   i2s_tx_wsdet i_wsdet (
      .sclk_i     (sclk_in),
      .rst_ni     (rst_n),
      .ws_i       (ws_in),
      .ws_level_o (ws_level),
      .ws_flip_o  (ws_flip)
   );

   i2s_tx_pkt_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
      .sclk_i  (sclk_in),
      .rst_ni  (rst_n),
      .cap_i   (cap),
      .valid_i (pkt_valid),
      .words_i (offered),
      .words_o (held)
   );

   i2s_tx_ser #(.SAMPLE_W(SAMPLE_W)) i_ser (
      .sclk_i     (sclk_in),
      .rst_ni     (rst_n),
      .ws_level_i (ws_level),
      .ws_flip_i  (ws_flip),
      .words_i    (held),
      .sd_o       (sd_out),
      .cap_o      (cap)
   );

endmodule

// File: tb/test_i2s_tgt_tx.sv
`timescale 1ns/1ps
module test_i2s_tgt_tx;

   localparam int W = 16;
   localparam int NV = 10;

   // {valid, left, right}
   localparam logic [2*W:0] VECS [NV] = '{
      {1'b1, 16'hA5A5, 16'h5A5A},
      {1'b1, 16'h8001, 16'h7FFE},
      {1'b1, 16'hFFFF, 16'h0000},
      {1'b0, 16'h1234, 16'hABCD},
      {1'b1, 16'h0000, 16'hFFFF},
      {1'b0, 16'hC3C3, 16'h3C3C},
      {1'b1, 16'h8000, 16'h0001},
      {1'b1, 16'h0F0F, 16'hF0F0},
      {1'b0, 16'hDEAD, 16'hBEEF},
      {1'b0, 16'h1111, 16'h2222}
   };

   logic          rst_n = 1'b0;
   logic          sclk_in = 1'b0;
   logic          ws_in = 1'b1;
   logic [W-1:0]  left_in = '0;
   logic [W-1:0]  right_in = '0;
   logic          pkt_valid = 1'b0;
   logic          sclk_out, ws_out, sd_out;

   int n_checks = 0;
   int n_fail   = 0;
   int r4_bad   = 0;
   bit done     = 0;

   always #2 sclk_in = ~sclk_in;

   i2s_tgt_tx #(.SAMPLE_W(W)) i_i2s_tgt_tx (
      .rst_n     (rst_n),
      .sclk_in   (sclk_in),
      .ws_in     (ws_in),
      .left_in   (left_in),
      .right_in  (right_in),
      .pkt_valid (pkt_valid),
      .sclk_out  (sclk_out),
      .ws_out    (ws_out),
      .sd_out    (sd_out)
   );

   // independent I2S receiver: a word ends with the bit sampled when ws is first seen changed
   logic [W-1:0] rx_sh = '0;
   logic         rx_ws = 1'b1;
   logic [W-1:0] rx_l = '0, got_l = '0, got_r = '0;
   always @(posedge sclk_in) begin
      if (ws_out != rx_ws) begin
         if (!rx_ws) rx_l <= {rx_sh[W-2:0], sd_out};
         else begin
            got_l <= rx_l;
            got_r <= {rx_sh[W-2:0], sd_out};
         end
      end
      rx_sh <= {rx_sh[W-2:0], sd_out};
      rx_ws <= ws_out;
   end

   // R4 monitor: the line seen mid low phase must still hold at the rising edge
   logic sd_mid = 1'b0;
   always @(negedge sclk_in) begin
      #1 sd_mid = sd_out;
   end
   always @(posedge sclk_in) begin
      if (rst_n && sd_out !== sd_mid) r4_bad++;
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic present(input logic [W-1:0] l, input logic [W-1:0] r, input logic v);
      #1;
      left_in = l;
      right_in = r;
      pkt_valid = v;
   endtask

   // one frame: ws low for W bits then high for W bits; optional packet switch after negedge sw
   task automatic run_frame(input int sw, input logic [W-1:0] l2, input logic [W-1:0] r2);
      for (int j = 0; j < 2*W; j++) begin
         @(negedge sclk_in);
         ws_in <= (j >= W);
         if (j == sw) begin
            #1;
            left_in = l2;
            right_in = r2;
            pkt_valid = 1'b1;
         end
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2*W-1:0] exp_pk [NV];
      logic [2*W-1:0] hold;
      logic [2*W-1:0] want;

      repeat (4) @(negedge sclk_in);
      #1 check("R7 line low in reset", {31'b0, sd_out}, 32'h0);
      rst_n = 1'b1;
      repeat (40) @(negedge sclk_in);
      check("R7 line low after reset", {31'b0, sd_out}, 32'h0);

      @(posedge sclk_in); #1;
      check("R1 sclk high", {31'b0, sclk_out}, {31'b0, sclk_in});
      ws_in = 1'b0; #0.1;
      check("R1 ws follows", {31'b0, ws_out}, 32'h0);
      @(negedge sclk_in); #1;
      check("R1 sclk low", {31'b0, sclk_out}, 32'h0);
      ws_in = 1'b1;
      @(negedge sclk_in);

      // table walk: packet offered in frame i is heard completed two frames later
      hold = '0;
      for (int i = 0; i < NV; i++) begin
         present(VECS[i][2*W-1:W], VECS[i][W-1:0], VECS[i][2*W]);
         if (VECS[i][2*W]) hold = VECS[i][2*W-1:0];
         exp_pk[i] = hold;
         run_frame(-1, '0, '0);
         if (i >= 1) begin
            want = (i == 1) ? '0 : exp_pk[i-2];
            check($sformatf("R2 R3 R6 left vec%0d", i), {16'b0, got_l}, {16'b0, want[2*W-1:W]});
            check($sformatf("R2 R3 R6 right vec%0d", i), {16'b0, got_r}, {16'b0, want[W-1:0]});
         end
      end

      // R5 load point: switch one bit before it, then one bit after it
      present(16'h1357, 16'h2468, 1'b1);
      run_frame(30, 16'h9ABC, 16'hDEF0);
      run_frame(31, 16'h4242, 16'hFFFF);
      run_frame(-1, '0, '0);
      check("R5 change before load edge used", {got_l, got_r}, 32'h9ABC_DEF0);
      run_frame(-1, '0, '0);
      check("R5 change after load edge deferred", {got_l, got_r}, 32'h9ABC_DEF0);
      run_frame(-1, '0, '0);
      check("R5 deferred packet arrives", {got_l, got_r}, 32'h4242_FFFF);

      // R7 reset in the middle of a right word of all ones
      #1 check("R2 right word on line", {31'b0, sd_out}, 32'h1);
      rst_n = 1'b0;
      #1 check("R7 async clear of line", {31'b0, sd_out}, 32'h0);
      pkt_valid = 1'b0;
      repeat (5) @(negedge sclk_in);
      #1 rst_n = 1'b1;
      run_frame(-1, '0, '0);
      run_frame(-1, '0, '0);
      check("R7 cleared packet sent", {got_l, got_r}, 32'h0);
      run_frame(-1, '0, '0);
      check("R7 cleared packet repeated", {got_l, got_r}, 32'h0);

      check("R4 line stable at rising edges", r4_bad, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule